// File: doc/BRIEF.md
# Local Bus Cycle Strobe Sequencer

This block runs the data phase of a simple master cycle on a local bus. The requester presents a transfer (direction and burst length) together with the timing descriptor of the targeted region. The sequencer then walks through the address-to-data wait states, the data beats and the data-to-data wait states, and an optional write hold. It drives the write strobe, a data-bus drive enable and a wait-status output, and it pulses a beat-done signal for every completed data beat.

Each region chooses how a beat ends. With the ready-enable bit clear, the beat ends as soon as the internal wait counter has run out, and the external ready input plays no part. With the bit set, a slave that is being accessed can stretch every data cycle for as long as it needs, by holding ready low. While the internal counter is still running, the wait-status output is high and ready is not looked at. For writes, the strobe start can be delayed by a programmable number of clocks counted from the start of the cycle, and the data bus can be kept driven for a programmable number of clocks after the strobe drops.

Top module: `lbus_strobe_seq`

## Requirements
- R1: After reset, and whenever the sequencer is idle, `seq_idle` is 1 and `wait_stat`, `wr_strobe`, `data_oe` and `beat_done` are 0.
- R2: A request accepted while idle is followed by exactly `cfg_nwad` cycles with `wait_stat`=1 before the first data cycle. A count of 0 gives no wait cycles.
- R3: Between consecutive beats of a burst there are exactly N cycles with `wait_stat`=1, where N is the `cfg_nwdd` value latched at acceptance. A value of 0 inserts none.
- R4: With `cfg_rdy_en`=0, each beat completes in its first data cycle (the cycle right after its wait cycles), whatever the value of `ext_ready`.
- R5: With `cfg_rdy_en`=1, a data cycle completes only in a cycle where `ext_ready`=1. The slave may hold `ext_ready` low for any number of cycles.
- R6: `ext_ready` is not sampled while `wait_stat`=1: `beat_done` is 0 in every cycle with `wait_stat`=1, even when `ext_ready`=1.
- R7: Number the active cycles of a write from 0, where cycle 0 is the first cycle after acceptance. `wr_strobe` is 1 in active cycle k exactly when k >= `cfg_wsd`, where `cfg_wsd` is 2 bits wide. A delay of 0 raises the strobe in cycle 0.
- R8: Once raised, `wr_strobe` stays high through all wait cycles and burst beats, and falls after the cycle in which the last beat completes.
- R9: A write keeps `data_oe` high through all of its active cycles and then for exactly `cfg_whold` further cycles with `wr_strobe`=0. `cfg_whold` is 2 bits wide, and 0 adds no cycles.
- R10: `beat_done` is high for one cycle for each beat, `req_len`+1 times per transfer (`req_len` holds the beat count minus one). The sequencer is idle in the cycle after the last beat, or after the last hold cycle.
- R11: A read never raises `wr_strobe` or `data_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a transfer; only taken while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | LEN_W | Number of beats minus one |
| cfg_rdy_en | input | 1 | 1 = beats end on external ready |
| cfg_nwad | input | CNT_W | Address-to-data wait cycles |
| cfg_nwdd | input | CNT_W | Data-to-data wait cycles |
| cfg_wsd | input | 2 | Write strobe delay in clocks |
| cfg_whold | input | 2 | Data drive hold after the strobe, in clocks |
| ext_ready | input | 1 | Ready from the addressed slave |
| seq_idle | output | 1 | Sequencer idle, a request can be taken |
| wait_stat | output | 1 | Internal wait states being counted |
| wr_strobe | output | 1 | Write strobe, active high |
| data_oe | output | 1 | Drive enable for the write data bus |
| beat_done | output | 1 | One data beat completed this cycle |

## Verification
All outputs are decoded from registered state, except `beat_done`, which also follows `ext_ready` within the same cycle. The first active cycle therefore appears one clock after the edge that takes the request. From then on, every following clock advances the expected schedule by exactly one step: the wait cycles, then the data cycles (stretched by the number of low-ready cycles the bench chooses), then the hold cycles, then idle. The bench builds this schedule arithmetically from the configuration and compares every output in every cycle. It changes `ext_ready` on the falling edge and samples shortly afterwards, so the combinational path of `beat_done` has settled before the check and no result depends on the order of processes at the rising edge.

// File: rtl/lbus_seq_pkg.sv
package lbus_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DATA = 2'd2,
        ST_HOLD = 2'd3
    } seq_state_t;

endpackage

// File: rtl/lbus_wait_ctr.sv
module lbus_wait_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         cnt_last,
    output logic         cnt_busy
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_last = (cnt_q == ONE);
    assign cnt_busy = (cnt_q != '0);

    // R2
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_busy && !load) |=> !cnt_busy);

endmodule

// File: rtl/lbus_wstrobe_gen.sv
module lbus_wstrobe_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] wsd,
    input  logic       is_write,
    input  logic       active,
    output logic       wr_strobe
);

    logic [1:0] dly_d, dly_q;

    always_comb begin
        dly_d = dly_q;
        if (start) begin
            dly_d = wsd;
        end else if (dly_q != 2'd0) begin
            dly_d = dly_q - 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q <= 2'd0;
        else        dly_q <= dly_d;
    end

    assign wr_strobe = is_write && active && (dly_q == 2'd0);

    // R8
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && !start) |=> (wr_strobe || !active));

endmodule

// File: rtl/lbus_strobe_seq.sv
module lbus_strobe_seq
    import lbus_seq_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LEN_W-1:0] req_len,
    input  logic             cfg_rdy_en,
    input  logic [CNT_W-1:0] cfg_nwad,
    input  logic [CNT_W-1:0] cfg_nwdd,
    input  logic [1:0]       cfg_wsd,
    input  logic [1:0]       cfg_whold,
    input  logic             ext_ready,
    output logic             seq_idle,
    output logic             wait_stat,
    output logic             wr_strobe,
    output logic             data_oe,
    output logic             beat_done
);

    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    typedef struct packed {
        seq_state_t       state;
        logic             write;
        logic             rdy_en;
        logic [CNT_W-1:0] nwdd;
        logic [1:0]       whold;
        logic [LEN_W-1:0] left;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic             ctr_load;
    logic [CNT_W-1:0] ctr_val;
    logic             ctr_dec;
    logic             ctr_last;
    logic             ctr_busy;
    logic             start;
    logic             active;
    logic             beat_ok;

    always_comb begin
        r_d      = r_q;
        ctr_load = 1'b0;
        ctr_val  = '0;
        start    = 1'b0;
        beat_ok  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    start    = 1'b1;
                    r_d.write  = req_write;
                    r_d.rdy_en = cfg_rdy_en;
                    r_d.nwdd   = cfg_nwdd;
                    r_d.whold  = cfg_whold;
                    r_d.left   = req_len;
                    if (cfg_nwad != '0) begin
                        r_d.state = ST_WAIT;
                        ctr_load  = 1'b1;
                        ctr_val   = cfg_nwad;
                    end else begin
                        r_d.state = ST_DATA;
                    end
                end
            end
            ST_WAIT: begin
                if (ctr_last) r_d.state = ST_DATA;
            end
            ST_DATA: begin
                beat_ok = !r_q.rdy_en || ext_ready;
                if (beat_ok) begin
                    if (r_q.left != '0) begin
                        r_d.left = r_q.left - LEN_ONE;
                        if (r_q.nwdd != '0) begin
                            r_d.state = ST_WAIT;
                            ctr_load  = 1'b1;
                            ctr_val   = r_q.nwdd;
                        end
                    end else if (r_q.write && r_q.whold != 2'd0) begin
                        r_d.state = ST_HOLD;
                        ctr_load  = 1'b1;
                        ctr_val   = CNT_W'(r_q.whold);
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                if (ctr_last) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.write  <= 1'b0;
            r_q.rdy_en <= 1'b0;
            r_q.nwdd   <= '0;
            r_q.whold  <= 2'd0;
            r_q.left   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctr_dec = (r_q.state == ST_WAIT) || (r_q.state == ST_HOLD);
    assign active  = (r_q.state == ST_WAIT) || (r_q.state == ST_DATA);

    lbus_wait_ctr #(.W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_val),
        .dec      (ctr_dec),
        .cnt_last (ctr_last),
        .cnt_busy (ctr_busy)
    );

    lbus_wstrobe_gen u_wstb (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wsd       (cfg_wsd),
        .is_write  (r_q.write),
        .active    (active),
        .wr_strobe (wr_strobe)
    );

    assign seq_idle  = (r_q.state == ST_IDLE);
    assign wait_stat = (r_q.state == ST_WAIT);
    assign data_oe   = r_q.write && (r_q.state != ST_IDLE);
    assign beat_done = beat_ok;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_idle |-> (!wr_strobe && !data_oe && !wait_stat && !beat_done));

    // R6
    no_early_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_stat |-> !beat_done);

    // R2
    wait_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_stat |-> ctr_busy);

    // R9
    strobe_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> data_oe);

    // R9
    hold_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HOLD) |-> (data_oe && !wr_strobe && ctr_busy));

endmodule

// File: tb/lbus_strobe_seq_bench.sv
module lbus_strobe_seq_bench;

    localparam int CNT_W = 4;
    localparam int LEN_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [LEN_W-1:0] req_len = '0;
    logic             cfg_rdy_en = 1'b0;
    logic [CNT_W-1:0] cfg_nwad = '0;
    logic [CNT_W-1:0] cfg_nwdd = '0;
    logic [1:0]       cfg_wsd = 2'd0;
    logic [1:0]       cfg_whold = 2'd0;
    logic             ext_ready = 1'b0;
    logic             seq_idle, wait_stat, wr_strobe, data_oe, beat_done;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lbus_strobe_seq #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_lbus_strobe_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_len(req_len), .cfg_rdy_en(cfg_rdy_en), .cfg_nwad(cfg_nwad),
        .cfg_nwdd(cfg_nwdd), .cfg_wsd(cfg_wsd), .cfg_whold(cfg_whold),
        .ext_ready(ext_ready), .seq_idle(seq_idle), .wait_stat(wait_stat),
        .wr_strobe(wr_strobe), .data_oe(data_oe), .beat_done(beat_done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired got %0d cycles exp fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input string name, input logic got, input logic exp);
        tests = tests + 1;
        if (got !== exp) begin
            fails = fails + 1;
            $display("FAIL %s %s got %0b exp %0b", tag, name, got, exp);
        end
    endtask

    task automatic chk_all(input string ptag, input logic e_idle, input logic e_wait,
                           input logic e_wr, input logic e_oe, input logic e_beat);
        chk(ptag, "seq_idle", seq_idle, e_idle);
        chk(ptag, "wait_stat", wait_stat, e_wait);
        chk(ptag, "wr_strobe", wr_strobe, e_wr);
        chk(ptag, "data_oe", data_oe, e_oe);
        chk(ptag, "beat_done", beat_done, e_beat);
    endtask

    task automatic run_xfer(input int nwad, input int nwdd, input int wsd, input int whold,
                            input int len, input logic wr, input logic mode);
        int k;
        int beats;
        int extra;
        string wtag;
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_len    = LEN_W'(len);
        cfg_rdy_en = mode;
        cfg_nwad   = CNT_W'(nwad);
        cfg_nwdd   = CNT_W'(nwdd);
        cfg_wsd    = 2'(wsd);
        cfg_whold  = 2'(whold);
        ext_ready  = 1'b0;
        k = 0;
        beats = 0;
        wtag = wr ? "R7/R8" : "R11";
        for (int b = 0; b <= len; b++) begin
            int w;
            w = (b == 0) ? nwad : nwdd;
            for (int i = 0; i < w; i++) begin
                @(negedge clk);
                req_valid = 1'b0;
                ext_ready = mode;
                #0.5;
                // R2 R3 R6: wait cycle, ready ignored
                chk((b == 0) ? "R2" : "R3", "wait_stat", wait_stat, 1'b1);
                chk("R6", "beat_done", beat_done, 1'b0);
                chk(wtag, "wr_strobe", wr_strobe, wr && (k >= wsd));
                chk(wr ? "R9" : "R11", "data_oe", data_oe, wr);
                chk("R10", "seq_idle", seq_idle, 1'b0);
                k++;
            end
            extra = mode ? ((b + nwad) % 3) : 0;
            for (int x = 0; x <= extra; x++) begin
                @(negedge clk);
                req_valid = 1'b0;
                ext_ready = mode ? (x == extra) : 1'((x + b + 1) % 2);
                #0.5;
                chk(mode ? "R5" : "R4", "beat_done", beat_done, x == extra);
                chk((b == 0) ? "R2" : "R3", "wait_stat", wait_stat, 1'b0);
                chk(wtag, "wr_strobe", wr_strobe, wr && (k >= wsd));
                chk(wr ? "R9" : "R11", "data_oe", data_oe, wr);
                chk("R10", "seq_idle", seq_idle, 1'b0);
                if (beat_done) beats++;
                k++;
            end
        end
        if (wr) begin
            for (int h = 0; h < whold; h++) begin
                @(negedge clk);
                ext_ready = 1'b0;
                #0.5;
                chk_all("R9", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        ext_ready = 1'b0;
        #0.5;
        // R10: idle right after last beat or hold, beat count matches
        chk_all("R10", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        tests = tests + 1;
        if (beats != len + 1) begin
            fails = fails + 1;
            $display("FAIL R10 beat count got %0d exp %0d", beats, len + 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #0.5;
        // R1: reset state
        chk_all("R1", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #0.5;
        chk_all("R1", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int md = 0; md < 2; md++)
            for (int wr = 0; wr < 2; wr++)
                for (int na = 0; na < 3; na++)
                    for (int nd = 0; nd < 3; nd++)
                        for (int sd = 0; sd < 4; sd++)
                            for (int hd = 0; hd < 4; hd++)
                                for (int ln = 0; ln < 3; ln++)
                                    run_xfer(na, nd, sd, hd, ln, 1'(wr), 1'(md));
        // R5: long slave stall in ready mode
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_len = '0; cfg_rdy_en = 1'b1;
        cfg_nwad = '0; cfg_wsd = 2'd0; cfg_whold = 2'd0; ext_ready = 1'b0;
        for (int s = 0; s < 40; s++) begin
            @(negedge clk);
            req_valid = 1'b0;
            #0.5;
            chk("R5", "beat_done", beat_done, 1'b0);
            chk("R8", "wr_strobe", wr_strobe, 1'b1);
        end
        @(negedge clk);
        ext_ready = 1'b1;
        #0.5;
        chk("R5", "beat_done", beat_done, 1'b1);
        @(negedge clk);
        ext_ready = 1'b0;
        #0.5;
        chk_all("R10", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule